// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer (Three-Wire Plus Select)

This block is the host side of a four-signal serial link to a 64-word by 16-bit EEPROM. A client hands it one command at a time (an operation code, a word address and, for the two data-carrying writes, a 16-bit value) through a valid/ready handshake. The sequencer raises the chip select, generates the serial clock from the system clock with a programmable half period, shifts the frame out on the data-in pin and, for a read, collects the returned word from the data-out pin.

After any operation that changes the array, the sequencer lowers the chip select straight after the final bit. This starts the device's self-timed programming. It holds the select low for a programmable minimum time and then raises it again with the serial clock idle, to watch the ready/busy level on data-out. When ready appears, it clocks a single start bit to release data-out and closes the transaction. If ready never comes within a programmable window, the transaction ends with an error flag. The client sees a one-cycle completion pulse, a busy level and the read word.

Top module: `mw_eeprom_host`

## Requirements
- R1: After reset, and whenever no command is running, chip select, serial clock and data-in are low, `cmd_ready` is high, and `busy`, `done` and `err` are low. The serial clock is never high while chip select is low.
- R2: Each frame begins with a 1 start bit, followed by a 2-bit opcode and 6 address bits, all most significant bit first. The `cmd_op` codes map as follows: 0 read (opcode 10, address as given), 1 write (01, address), 2 erase (11, address), 3 enable writes (00, address 11 0000), 4 disable writes (00, address 00 0000), 5 fill all words (00, address 01 0000), 6 erase all (00, address 10 0000). Code 7 is sent as disable writes. Data-in changes only while the serial clock is low, so it is steady at every rising edge.
- R3: Write and fill-all frames append the 16 data bits, most significant first, for a total of 25 rising edges. Erase, erase-all, enable and disable frames have exactly 9 rising edges.
- R4: A read frame has 25 rising edges. The data-out bit present after rising edge 9 is a dummy and is discarded. The bits present after rising edges 10 to 25 form `rd_data`, bit 15 first. `rd_data` is valid with `done`.
- R5: While a frame is being clocked, the serial clock is high for exactly SK_HALF system clocks and low for SK_HALF system clocks. The first rising edge comes SK_HALF clocks after chip select rises.
- R6: Chip select falls after the final bit, before any further rising edge. Each low period of chip select lasts at least CS_LOW_MIN system clocks.
- R7: After write, erase, fill-all or erase-all, chip select is raised again with the serial clock held low. Data-out is sampled once per SK_HALF clocks. On the first high sample, exactly one serial clock pulse with data-in at 1 is sent, and then chip select is lowered.
- R8: Read, enable and disable commands do no status polling. Chip select stays low after their frame until `done`.
- R9: If data-out stays low for POLL_LIMIT clocks of polling, chip select is lowered with no clock pulse and the command completes with `err` high. `err` stays high until the next command is accepted.
- R10: A command is taken only on a clock where `cmd_valid` and `cmd_ready` are both high. Chip select rises on the next clock. `cmd_ready` is low for the whole transaction, and a `cmd_valid` presented during that time is neither taken nor sent.
- R11: `done` is a one-cycle pulse in the first cycle that `cmd_ready` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_addr | input | 6 | Word address |
| cmd_wdata | input | 16 | Write data for write and fill-all |
| rd_data | output | 16 | Word returned by the last read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transaction in progress |
| err | output | 1 | Last command hit the poll timeout |
| mw_cs | output | 1 | Chip select to the EEPROM |
| mw_sk | output | 1 | Serial clock to the EEPROM |
| mw_di | output | 1 | Serial data to the EEPROM |
| mw_do | input | 1 | Serial data and ready/busy from the EEPROM |

## Verification
A wrong bit counter or frame length shows up at the device pins within the same transaction. The EEPROM sees 24 or 26 rising edges instead of 25, or a clear pulse at the end of a frame that should not have one. A wrong opcode or address builder changes the captured frame bits at once. A fault in the sequencing state is different: it shows only at the end of a command, as a missing or doubled one-bit clearing frame, a chip-select low gap that is too short, or a `done` that arrives with the wrong `err`. A capture window off by one edge shifts every read word by one bit, which the first read-back of a known pattern exposes.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;

    localparam int MW_AW    = 6;
    localparam int MW_DW    = 16;
    localparam int MW_HDR   = 1 + 2 + MW_AW;
    localparam int MW_FRAME = MW_HDR + MW_DW;
    localparam int MW_LW    = $clog2(MW_FRAME + 1);

    typedef enum logic [2:0] {
        OP_RD   = 3'd0,
        OP_WR   = 3'd1,
        OP_ER   = 3'd2,
        OP_EN   = 3'd3,
        OP_DIS  = 3'd4,
        OP_WALL = 3'd5,
        OP_EALL = 3'd6
    } mw_op_e;

    typedef struct packed {
        logic [MW_FRAME-1:0] bits;
        logic [MW_LW-1:0]    len;
        logic                modifies;
        logic                reads;
    } mw_frame_t;

    function automatic mw_frame_t mw_build(input logic [2:0] code,
                                           input logic [MW_AW-1:0] a,
                                           input logic [MW_DW-1:0] d);
        mw_frame_t       f;
        logic [1:0]      opc;
        logic [MW_AW-1:0] ad;
        logic            with_data;
        ad         = a;
        with_data  = 1'b0;
        f.modifies = 1'b0;
        f.reads    = 1'b0;
        case (mw_op_e'(code))
            OP_RD: begin
                opc     = 2'b10;
                f.reads = 1'b1;
            end
            OP_WR: begin
                opc        = 2'b01;
                with_data  = 1'b1;
                f.modifies = 1'b1;
            end
            OP_ER: begin
                opc        = 2'b11;
                f.modifies = 1'b1;
            end
            OP_WALL: begin
                opc        = 2'b00;
                ad         = {2'b01, {(MW_AW-2){1'b0}}};
                with_data  = 1'b1;
                f.modifies = 1'b1;
            end
            OP_EALL: begin
                opc        = 2'b00;
                ad         = {2'b10, {(MW_AW-2){1'b0}}};
                f.modifies = 1'b1;
            end
            OP_EN: begin
                opc = 2'b00;
                ad  = {2'b11, {(MW_AW-2){1'b0}}};
            end
            default: begin
                opc = 2'b00;
                ad  = {MW_AW{1'b0}};
            end
        endcase
        f.bits = {1'b1, opc, ad, (with_data ? d : {MW_DW{1'b0}})};
        f.len  = (with_data || f.reads) ? MW_LW'(MW_FRAME) : MW_LW'(MW_HDR);
        return f;
    endfunction

endpackage

// File: rtl/mw_tick.sv
`timescale 1ns/1ps
module mw_tick #(
    parameter int HALF = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(HALF + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (cnt == CW'(HALF - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == CW'(HALF - 1));
endmodule

// File: rtl/mw_sync.sv
`timescale 1ns/1ps
module mw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] r;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= {r[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = r[STAGES-1];
endmodule

// File: rtl/mw_rx.sv
`timescale 1ns/1ps
module mw_rx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)
            word <= '0;
        else if (cap)
            word <= {word[W-2:0], bit_in};
    end
endmodule

// File: rtl/mw_eeprom_host.sv
`timescale 1ns/1ps
module mw_eeprom_host
    import mw_pkg::*;
#(
    parameter int SK_HALF     = 8,
    parameter int CS_LOW_MIN  = 8,
    parameter int POLL_LIMIT  = 100000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [2:0]          cmd_op,
    input  logic [MW_AW-1:0]    cmd_addr,
    input  logic [MW_DW-1:0]    cmd_wdata,
    output logic [MW_DW-1:0]    rd_data,
    output logic                done,
    output logic                busy,
    output logic                err,
    output logic                mw_cs,
    output logic                mw_sk,
    output logic                mw_di,
    input  logic                mw_do
);
    localparam int WCW      = $clog2(CS_LOW_MIN + 1);
    localparam int PCW      = $clog2(POLL_LIMIT + 1);
    localparam int RX_FIRST = MW_HDR + 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LEAD, ST_SHIFT, ST_GAP, ST_POLL, ST_CLR_LO, ST_CLR_HI, ST_TAIL
    } st_e;

    st_e                 state;
    mw_frame_t           nxt_fr;
    logic [MW_FRAME-1:0] sh;
    logic [MW_LW-1:0]    len;
    logic [MW_LW-1:0]    rises;
    logic [WCW-1:0]      wcnt;
    logic [PCW-1:0]      pcnt;
    logic                is_mod;
    logic                is_rd;
    logic                tick;
    logic                tick_en;
    logic                do_s;
    logic                rx_cap;
    logic [MW_DW-1:0]    rx_word;

    always_comb nxt_fr = mw_build(cmd_op, cmd_addr, cmd_wdata);

    assign tick_en = (state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_POLL) ||
                     (state == ST_CLR_LO) || (state == ST_CLR_HI);

    mw_tick #(.HALF(SK_HALF)) i_tick (
        .clk (clk),
        .rst (rst),
        .en  (tick_en),
        .tick(tick)
    );

    mw_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk),
        .rst(rst),
        .d  (mw_do),
        .q  (do_s)
    );

    assign rx_cap = tick && (state == ST_SHIFT) && mw_sk && is_rd &&
                    (rises >= MW_LW'(RX_FIRST));

    mw_rx #(.W(MW_DW)) i_rx (
        .clk   (clk),
        .rst   (rst),
        .cap   (rx_cap),
        .bit_in(do_s),
        .word  (rx_word)
    );

    assign cmd_ready = (state == ST_IDLE);
    assign busy      = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            mw_cs   <= 1'b0;
            mw_sk   <= 1'b0;
            mw_di   <= 1'b0;
            sh      <= '0;
            len     <= '0;
            rises   <= '0;
            wcnt    <= '0;
            pcnt    <= '0;
            is_mod  <= 1'b0;
            is_rd   <= 1'b0;
            err     <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        sh     <= nxt_fr.bits;
                        len    <= nxt_fr.len;
                        is_mod <= nxt_fr.modifies;
                        is_rd  <= nxt_fr.reads;
                        mw_di  <= nxt_fr.bits[MW_FRAME-1];
                        mw_cs  <= 1'b1;
                        rises  <= '0;
                        err    <= 1'b0;
                        state  <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        mw_sk <= 1'b1;
                        rises <= MW_LW'(1);
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (mw_sk) begin
                            mw_sk <= 1'b0;
                            if (rises == len) begin
                                mw_cs <= 1'b0;
                                mw_di <= 1'b0;
                                wcnt  <= '0;
                                state <= is_mod ? ST_GAP : ST_TAIL;
                            end else begin
                                sh    <= {sh[MW_FRAME-2:0], 1'b0};
                                mw_di <= sh[MW_FRAME-2];
                            end
                        end else begin
                            mw_sk <= 1'b1;
                            rises <= rises + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (wcnt == WCW'(CS_LOW_MIN - 1)) begin
                        mw_cs <= 1'b1;
                        pcnt  <= '0;
                        state <= ST_POLL;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_POLL: begin
                    if (tick && do_s) begin
                        mw_di <= 1'b1;
                        state <= ST_CLR_LO;
                    end else if (pcnt == PCW'(POLL_LIMIT - 1)) begin
                        mw_cs <= 1'b0;
                        err   <= 1'b1;
                        wcnt  <= '0;
                        state <= ST_TAIL;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                ST_CLR_LO: begin
                    if (tick) begin
                        mw_sk <= 1'b1;
                        state <= ST_CLR_HI;
                    end
                end
                ST_CLR_HI: begin
                    if (tick) begin
                        mw_sk <= 1'b0;
                        mw_cs <= 1'b0;
                        mw_di <= 1'b0;
                        wcnt  <= '0;
                        state <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    if (wcnt == WCW'(CS_LOW_MIN - 1)) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                        if (is_rd)
                            rd_data <= rx_word;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mw_eeprom_host_chk.sv
`timescale 1ns/1ps
module mw_eeprom_host_chk #(
    parameter int SK_HALF    = 8,
    parameter int CS_LOW_MIN = 8
) (
    input logic clk,
    input logic rst,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic busy,
    input logic done,
    input logic mw_cs,
    input logic mw_sk,
    input logic mw_di
);
    logic [15:0] low_cnt;
    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            low_cnt <= '1;
        else if (mw_cs)
            low_cnt <= '0;
        else if (low_cnt != '1)
            low_cnt <= low_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            hi_cnt <= '0;
        else if (mw_sk)
            hi_cnt <= hi_cnt + 1'b1;
        else
            hi_cnt <= '0;
    end

    // R1
    sk_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !mw_cs |-> !mw_sk);

    // R2
    di_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mw_sk |-> $stable(mw_di));

    // R5
    sk_high_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mw_sk) |-> (hi_cnt == 16'(SK_HALF)));

    // R6
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mw_cs) |-> (low_cnt >= 16'(CS_LOW_MIN)));

    // R10
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> (busy && $rose(mw_cs)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    done_ready_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (cmd_ready && $past(busy)));
endmodule

bind mw_eeprom_host mw_eeprom_host_chk #(
    .SK_HALF   (SK_HALF),
    .CS_LOW_MIN(CS_LOW_MIN)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .busy     (busy),
    .done     (done),
    .mw_cs    (mw_cs),
    .mw_sk    (mw_sk),
    .mw_di    (mw_di)
);

// File: tb/test_mw_eeprom_host.sv
`timescale 1ns/1ps
module test_mw_eeprom_host;
    localparam int SKH  = 5;
    localparam int CSL  = 6;
    localparam int PLIM = 400;
    localparam int NV   = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = 3'd0;
    logic [5:0]  cmd_addr = 6'd0;
    logic [15:0] cmd_wdata = 16'd0;
    logic [15:0] rd_data;
    logic        done, busy, err;
    logic        mw_cs, mw_sk, mw_di;
    logic        mw_do = 1'b1;

    always #2.5 clk = ~clk;

    mw_eeprom_host #(
        .SK_HALF   (SKH),
        .CS_LOW_MIN(CSL),
        .POLL_LIMIT(PLIM)
    ) i_mw_eeprom_host (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rd_data(rd_data), .done(done), .busy(busy), .err(err),
        .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do)
    );

    // ---------------- behavioural EEPROM model and pin monitors ----------------
    int          busy_len = 100;
    int          m_bits, busy_left, cyc, last_rise, f_min, f_max, low_start, low_min;
    logic [31:0] m_sh;
    logic        p_cs, p_sk, wen, stat, rding;
    logic [15:0] word;
    logic [15:0] mem [64];
    int          lg_n;
    int          lg_bits [256];
    logic [31:0] lg_sh   [256];
    int          lg_pmin [256];
    int          lg_pmax [256];

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            m_bits = 0; m_sh = 0; busy_left = 0; last_rise = -1;
            f_min = 1000000; f_max = 0; low_start = 0; low_min = 1000000;
            p_cs = 0; p_sk = 0; wen = 0; stat = 0; rding = 0; lg_n = 0; word = 0;
            for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
            mw_do <= 1'b1;
        end else begin
            if (busy_left > 0) busy_left = busy_left - 1;
            if (mw_cs && !p_cs) begin
                if (cyc - low_start < low_min) low_min = cyc - low_start;
                m_bits = 0; m_sh = 0; rding = 0;
                f_min = 1000000; f_max = 0; last_rise = -1;
            end
            if (mw_cs && mw_sk && !p_sk) begin
                m_sh   = {m_sh[30:0], mw_di};
                m_bits = m_bits + 1;
                if (last_rise >= 0) begin
                    if (cyc - last_rise < f_min) f_min = cyc - last_rise;
                    if (cyc - last_rise > f_max) f_max = cyc - last_rise;
                end
                last_rise = cyc;
                if (stat && m_bits == 1 && mw_di) stat = 0;
                if (m_bits == 9 && m_sh[8:6] == 3'b110) begin
                    rding = 1; word = mem[m_sh[5:0]]; mw_do <= 1'b0;
                end else if (rding && m_bits >= 10 && m_bits <= 25) begin
                    mw_do <= word[25 - m_bits];
                end
            end
            if (!mw_cs && p_cs) begin
                low_start = cyc;
                lg_bits[lg_n % 256] = m_bits;
                lg_sh[lg_n % 256]   = m_sh;
                lg_pmin[lg_n % 256] = f_min;
                lg_pmax[lg_n % 256] = f_max;
                lg_n = lg_n + 1;
                mw_do <= 1'b1;
                if (m_bits == 9 && m_sh[8]) begin
                    if (m_sh[7:6] == 2'b11 && wen) begin
                        mem[m_sh[5:0]] = 16'hFFFF; stat = 1; busy_left = busy_len;
                    end else if (m_sh[7:6] == 2'b00) begin
                        if (m_sh[5:4] == 2'b11) wen = 1;
                        else if (m_sh[5:4] == 2'b00) wen = 0;
                        else if (m_sh[5:4] == 2'b10 && wen) begin
                            for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
                            stat = 1; busy_left = busy_len;
                        end
                    end
                end else if (m_bits == 25 && m_sh[24] && wen) begin
                    if (m_sh[23:22] == 2'b01) begin
                        mem[m_sh[21:16]] = m_sh[15:0]; stat = 1; busy_left = busy_len;
                    end else if (m_sh[23:22] == 2'b00 && m_sh[21:20] == 2'b01) begin
                        for (int i = 0; i < 64; i++) mem[i] = m_sh[15:0];
                        stat = 1; busy_left = busy_len;
                    end
                end
            end
            if (mw_cs && m_bits == 0 && stat) mw_do <= (busy_left == 0);
            p_cs = mw_cs;
            p_sk = mw_sk;
        end
    end

    // ---------------- bookkeeping ----------------
    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic logic [24:0] exp_frame(input logic [2:0] op, input logic [5:0] a,
                                              input logic [15:0] d, output int len);
        logic [8:0] h;
        case (op)
            3'd0: h = {3'b110, a};
            3'd1: h = {3'b101, a};
            3'd2: h = {3'b111, a};
            3'd3: h = 9'b100_11_0000;
            3'd5: h = 9'b100_01_0000;
            3'd6: h = 9'b100_10_0000;
            default: h = 9'b100_00_0000;
        endcase
        if (op == 3'd1 || op == 3'd5) begin len = 25; return {h, d}; end
        if (op == 3'd0)               begin len = 25; return {h, 16'h0000}; end
        len = 9;
        return {16'h0000, h};
    endfunction

    function automatic bit is_mod(input logic [2:0] op);
        return (op == 3'd1 || op == 3'd2 || op == 3'd5 || op == 3'd6);
    endfunction

    task automatic issue(input logic [2:0] op, input logic [5:0] a, input logic [15:0] d);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int k = 0; k < 20000; k++) begin
            if (done) begin ok = 1; return; end
            @(negedge clk);
        end
        check(0, "watchdog: done never seen", 0, 1);
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [5:0] a, input logic [15:0] d,
                           input logic [15:0] exp_rd, input bit chk_rd);
        int          base, len;
        bit          ok;
        logic [24:0] ef;
        base = lg_n;
        ef   = exp_frame(op, a, d, len);
        issue(op, a, d);
        wait_done(ok);
        if (!ok) return;
        check(busy == 0 && cmd_ready == 1, "R11 done with ready", {busy, cmd_ready}, 2'b01);
        check(err == 0, "R9 err low on normal completion", err, 0);
        // R3 frame length
        check(lg_bits[base % 256] == len, "R3 rising edges in frame", lg_bits[base % 256], len);
        // R2 frame bits
        check((lg_sh[base % 256] & ((32'd1 << len) - 1)) == 32'(ef), "R2 frame content",
              lg_sh[base % 256] & ((32'd1 << len) - 1), ef);
        // R5 clock period
        check(lg_pmin[base % 256] == 2 * SKH && lg_pmax[base % 256] == 2 * SKH,
              "R5 SK period", lg_pmax[base % 256], 2 * SKH);
        if (is_mod(op)) begin
            check(lg_n - base == 2 && lg_bits[(base + 1) % 256] == 1 && lg_sh[(base + 1) % 256][0],
                  "R7 poll then single clear bit", lg_bits[(base + 1) % 256], 1);
        end else begin
            check(lg_n - base == 1, "R8 no poll frame", lg_n - base, 1);
        end
        if (chk_rd) check(rd_data == exp_rd, "R4 read word", rd_data, exp_rd);
        @(negedge clk);
        check(done == 0, "R11 done single cycle", done, 0);
    endtask

    // op[40:38] addr[37:32] wdata[31:16] expected read[15:0]
    localparam logic [40:0] VEC [NV] = '{
        {3'd3, 6'd0,  16'h0000, 16'h0000},
        {3'd1, 6'd5,  16'hA5C3, 16'h0000},
        {3'd0, 6'd5,  16'h0000, 16'hA5C3},
        {3'd1, 6'd63, 16'h0001, 16'h0000},
        {3'd0, 6'd63, 16'h0000, 16'h0001},
        {3'd2, 6'd5,  16'h0000, 16'h0000},
        {3'd0, 6'd5,  16'h0000, 16'hFFFF},
        {3'd5, 6'd0,  16'h1234, 16'h0000},
        {3'd0, 6'd0,  16'h0000, 16'h1234},
        {3'd0, 6'd63, 16'h0000, 16'h1234},
        {3'd6, 6'd0,  16'h0000, 16'h0000},
        {3'd0, 6'd17, 16'h0000, 16'hFFFF},
        {3'd4, 6'd0,  16'h0000, 16'h0000},
        {3'd1, 6'd2,  16'h0F0F, 16'h0000},
        {3'd0, 6'd2,  16'h0000, 16'hFFFF}
    };

    initial begin
        int  base;
        bit  ok, saw_ready;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (20) @(negedge clk);

        // R1 reset / idle state
        check({mw_cs, mw_sk, mw_di} == 3'b000, "R1 idle pins", {mw_cs, mw_sk, mw_di}, 0);
        check(cmd_ready && !busy && !done && !err, "R1 idle status",
              {cmd_ready, busy, done, err}, 4'b1000);

        for (int i = 0; i < NV; i++) begin
            run_cmd(VEC[i][40:38], VEC[i][37:32], VEC[i][31:16], VEC[i][15:0],
                    VEC[i][40:38] == 3'd0);
        end

        // R10: valid held during a transaction is not taken
        run_cmd(3'd3, 6'd0, 16'h0, 16'h0, 0);
        base = lg_n;
        issue(3'd1, 6'd9, 16'hBEEF);
        cmd_op = 3'd4; cmd_valid = 1'b1; saw_ready = 0;
        for (int k = 0; k < 60; k++) begin
            if (cmd_ready) saw_ready = 1;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        check(!saw_ready, "R10 ready low while busy", saw_ready, 0);
        wait_done(ok);
        repeat (2) @(negedge clk);
        check(lg_n - base == 2 && lg_bits[base % 256] == 25, "R10 only one command sent",
              lg_n - base, 2);
        run_cmd(3'd0, 6'd9, 16'h0, 16'hBEEF, 1);
        run_cmd(3'd1, 6'd10, 16'h1111, 16'h0, 0);
        run_cmd(3'd0, 6'd10, 16'h0, 16'h1111, 1);   // R10 writes still enabled

        // R9 poll timeout
        busy_len = 1000;
        base = lg_n;
        issue(3'd1, 6'd20, 16'h5555);
        wait_done(ok);
        check(err == 1, "R9 timeout flags err", err, 1);
        check(lg_n - base == 2 && lg_bits[(base + 1) % 256] == 0, "R9 no clear pulse on timeout",
              lg_bits[(base + 1) % 256], 0);
        @(negedge clk);
        check(err == 1, "R9 err held after done", err, 1);
        repeat (1200) @(negedge clk);
        busy_len = 100;
        issue(3'd0, 6'd20, 16'h0);
        check(err == 0, "R9 err cleared on accept", err, 0);
        wait_done(ok);
        check(rd_data == 16'h5555, "R4 read after timeout", rd_data, 16'h5555);

        // R6 chip select low gap
        check(low_min >= CSL, "R6 minimum CS low", low_min, CSL);
        repeat (10) @(negedge clk);
        check({mw_cs, mw_sk} == 2'b00 && cmd_ready, "R1 idle after run", {mw_cs, mw_sk}, 0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog: run did not finish", 0, 1);
        finish_run();
    end
endmodule